// File: doc/BRIEF.md
# Triggered Bus Transaction Recorder

The recorder listens to a register bus between a microcontroller and FPGA logic. It never drives that bus. Each cycle that carries a read or write strobe counts as one transaction. Once the recorder is armed, a transaction that matches the programmed trigger starts capture. From then on, each transaction that the external filter accepts is stored as a record in a shallow on-chip FIFO. A record holds the direction, the address and the data value.

A host reaches the recorder through a small register port. Through it the host sets the trigger address, the trigger data, the data-match enable and the direction mode, and issues the arm command. It reads status and head records through the same port, and reading the head data word pops that record. The trigger can be changed at any time without rebuilding the design.

Top module: `txn_recorder`

## Requirements
- R1: A record holds the direction (1 for write, 0 for read), the bus address, and the data value. Write data is stored for writes and read data for reads. When both strobes are high in the same cycle, the transaction is a write.
- R2: Before the trigger fires, no transaction is recorded. The trigger fires on the first transaction after arming whose address equals the trigger address (register 1) and whose direction the mode allows.
- R3: When the data-match enable (control bit 1) is set, the trigger also needs the transaction data to equal the trigger data (register 2). When it is clear, the data is ignored.
- R4: The direction mode is control bits [3:2]: 01 allows reads only, 10 allows writes only, 11 allows either, and 00 allows none.
- R5: The triggering transaction is the first record stored if the filter accept input is high in that cycle. If the input is low, the trigger still fires but that transaction is not stored. After the trigger, only accepted transactions are stored.
- R6: Records are read out in arrival order, up to DEPTH of them. Register 4 returns {dir at bit 31, address in the low bits} of the head record. Register 5 returns the head data. Reading register 5 pops the head record, and a pop is ignored when the FIFO is empty.
- R7: A transaction that should be stored while the FIFO is full is dropped and sets a sticky overflow flag. While overflow is set, nothing more is stored, even after pops.
- R8: Writing 1 to control bit 0 arms the recorder. Arming clears the triggered state, the overflow flag and the FIFO. The armed flag clears when the trigger fires. After reset the recorder is idle and unarmed, so no trigger can fire.
- R9: Register 3 reports status: bit 0 armed, bit 1 triggered, bit 2 empty, bit 3 full, bit 4 overflow, bits [15:8] record count. Register 0 reads back the mode and data-match enable in bits [3:1], and bit 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | AW | Monitored bus address |
| bus_wdata_i | input | DW | Monitored write data |
| bus_rdata_i | input | DW | Monitored read data |
| bus_rd_i | input | 1 | Read strobe, one transaction per high cycle |
| bus_wr_i | input | 1 | Write strobe, one transaction per high cycle |
| filt_ok_i | input | 1 | External filter accepts this transaction |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_re_i | input | 1 | Configuration read strobe (pops on register 5) |
| cfg_addr_i | input | 3 | Configuration register index |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data, combinational from the index |

## Verification
The assertions check on every cycle that:
- the record count stays within the depth and moves by at most one, except when an arm flushes it to zero;
- nothing is stored before the trigger, while the FIFO is full, or while overflow is set;
- overflow stays set until the next arm;
- an arm leaves the FIFO empty and clears the triggered and overflow flags.

Only the bench scenarios can show that:
- record contents are correct and come out in arrival order;
- the direction modes and the data match gate the trigger correctly;
- a trigger transaction the filter rejects still starts capture;
- a trigger cannot fire while the recorder is unarmed.

// File: rtl/txn_rec_pkg.sv
package txn_rec_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_TADDR = 3'd1,
    REG_TDATA = 3'd2,
    REG_STAT  = 3'd3,
    REG_RADDR = 3'd4,
    REG_RDATA = 3'd5
  } reg_idx_e;

  localparam int CTRL_ARM = 0;
  localparam int CTRL_DM  = 1;
  localparam int CTRL_DIR = 2;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_RD   = 2'b01,
    DIR_WR   = 2'b10,
    DIR_ANY  = 2'b11
  } dir_mode_e;
endpackage

// File: rtl/txn_rec_regs.sv
module txn_rec_regs
  import txn_rec_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [AW-1:0] trig_addr_o,
  output logic [DW-1:0] trig_data_o,
  output logic          dm_en_o,
  output logic [1:0]    dir_mode_o,
  output logic          arm_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_addr_o <= '0;
      trig_data_o <= '0;
      dm_en_o     <= 1'b0;
      dir_mode_o  <= DIR_NONE;
    end else if (we_i) begin
      case (addr_i)
        REG_CTRL: begin
          dm_en_o    <= wdata_i[CTRL_DM];
          dir_mode_o <= wdata_i[CTRL_DIR +: 2];
        end
        REG_TADDR: trig_addr_o <= wdata_i[AW-1:0];
        REG_TDATA: trig_data_o <= wdata_i[DW-1:0];
        default: ;
      endcase
    end
  end

  assign arm_o = we_i && (addr_i == REG_CTRL) && wdata_i[CTRL_ARM];
endmodule

// File: rtl/txn_rec_trig.sv
module txn_rec_trig #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          filt_ok_i,
  input  logic [AW-1:0] trig_addr_i,
  input  logic [DW-1:0] trig_data_i,
  input  logic          dm_en_i,
  input  logic [1:0]    dir_mode_i,
  input  logic          full_i,
  output logic          armed_o,
  output logic          trig_o,
  output logic          ovf_o,
  output logic          hit_o,
  output logic          push_o
);
  logic armed_q, trig_q, ovf_q;
  logic txn, dir_ok, cap;

  assign txn    = rd_i | wr_i;
  assign dir_ok = wr_i ? dir_mode_i[1] : dir_mode_i[0];
  assign hit_o  = armed_q && !trig_q && txn && dir_ok && !arm_i &&
                  (addr_i == trig_addr_i) && (!dm_en_i || data_i == trig_data_i);
  assign cap    = txn && filt_ok_i && (trig_q || hit_o) && !ovf_q && !arm_i;
  assign push_o = cap && !full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      trig_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (hit_o) begin
        armed_q <= 1'b0;
        trig_q  <= 1'b1;
      end
      if (cap && full_i) ovf_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;
  assign trig_o  = trig_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/txn_rec_fifo.sv
module txn_rec_fifo #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    cnt_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  assign dout_o = mem[rp_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/txn_recorder.sv
module txn_recorder
  import txn_rec_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int RW = 1 + AW + DW,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_rd_i,
  input  logic          bus_wr_i,
  input  logic          filt_ok_i,
  input  logic          cfg_we_i,
  input  logic          cfg_re_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o
);
  logic [AW-1:0] trig_addr;
  logic [DW-1:0] trig_data, txn_data;
  logic          dm_en, arm_p, armed, trig_q, ovf_q, hit, push, pop, empty, full;
  logic [1:0]    dir_mode;
  logic [RW-1:0] rec_in, rec_out;
  logic [CW-1:0] cnt;

  // write wins when both strobes are high
  assign txn_data = bus_wr_i ? bus_wdata_i : bus_rdata_i;
  assign rec_in   = {bus_wr_i, bus_addr_i, txn_data};
  assign pop      = cfg_re_i && (cfg_addr_i == REG_RDATA);

  txn_rec_regs #(.AW(AW), .DW(DW)) i_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .trig_addr_o(trig_addr), .trig_data_o(trig_data),
    .dm_en_o(dm_en), .dir_mode_o(dir_mode), .arm_o(arm_p)
  );

  txn_rec_trig #(.AW(AW), .DW(DW)) i_trig (
    .clk_i, .rst_ni,
    .arm_i(arm_p), .rd_i(bus_rd_i), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .data_i(txn_data), .filt_ok_i,
    .trig_addr_i(trig_addr), .trig_data_i(trig_data),
    .dm_en_i(dm_en), .dir_mode_i(dir_mode), .full_i(full),
    .armed_o(armed), .trig_o(trig_q), .ovf_o(ovf_q),
    .hit_o(hit), .push_o(push)
  );

  txn_rec_fifo #(.WIDTH(RW), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .flush_i(arm_p), .push_i(push), .pop_i(pop),
    .din_i(rec_in), .dout_o(rec_out),
    .empty_o(empty), .full_o(full), .cnt_o(cnt)
  );

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      REG_CTRL:  cfg_rdata_o = {28'd0, dir_mode, dm_en, 1'b0};
      REG_TADDR: cfg_rdata_o = 32'(trig_addr);
      REG_TDATA: cfg_rdata_o = 32'(trig_data);
      REG_STAT:  cfg_rdata_o = {16'd0, 8'(cnt), 3'd0, ovf_q, full, empty, trig_q, armed};
      REG_RADDR: cfg_rdata_o = 32'(rec_out[DW +: AW]) | {rec_out[RW-1], 31'd0};
      REG_RDATA: cfg_rdata_o = 32'(rec_out[DW-1:0]);
      default:   cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/txn_recorder_chk.sv
module txn_recorder_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arm_i,
  input logic          push_i,
  input logic          hit_i,
  input logic          trig_i,
  input logic          ovf_i,
  input logic          full_i,
  input logic [CW-1:0] cnt_i
);
  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_i) <= DEPTH);

  p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (int'(cnt_i) <= int'($past(cnt_i)) + 1) && (int'(cnt_i) + 1 >= int'($past(cnt_i))));

  p_no_early_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (trig_i || hit_i));

  p_no_push_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !push_i);

  p_ovf_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |-> !push_i);

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !arm_i) |=> ovf_i);

  p_arm_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (cnt_i == '0) && !trig_i && !ovf_i);
endmodule

bind txn_recorder txn_recorder_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_p), .push_i(push),
  .hit_i(hit), .trig_i(trig_q), .ovf_i(ovf_q), .full_i(full), .cnt_i(cnt)
);

// File: tb/test_txn_recorder.sv
`timescale 1ns/1ps
module test_txn_recorder;
  localparam int AW = 16, DW = 16, DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, filt_ok = 1'b0;
  logic cfg_we = 1'b0, cfg_re = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;

  always #2.5 clk = ~clk;

  txn_recorder #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_txn_recorder (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .filt_ok_i(filt_ok),
    .cfg_we_i(cfg_we), .cfg_re_i(cfg_re), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  logic [32:0] mq[$];
  logic m_armed = 0, m_trig = 0, m_ovf = 0, m_dm = 0;
  logic [1:0] m_mode = 2'b00;
  logic [15:0] m_ta = '0, m_td = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    logic full = (mq.size() == DEPTH);
    logic empty = (mq.size() == 0);
    return {16'd0, 8'(mq.size()), 3'd0, m_ovf, full, empty, m_trig, m_armed};
  endfunction

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == 3'd0) begin
      m_dm = d[1]; m_mode = d[3:2];
      if (d[0]) begin m_armed = 1; m_trig = 0; m_ovf = 0; mq.delete(); end
    end else if (a == 3'd1) m_ta = d[15:0];
    else if (a == 3'd2) m_td = d[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic txn(logic rd, logic wr, logic [15:0] a, logic [15:0] wd,
                     logic [15:0] rdd, logic ok);
    logic [15:0] d;
    logic dir_ok, hit, cap;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; bus_rdata = rdd; filt_ok = ok;
    d = wr ? wd : rdd;
    dir_ok = wr ? m_mode[1] : m_mode[0];
    hit = m_armed && !m_trig && (rd || wr) && dir_ok && a == m_ta && (!m_dm || d == m_td);
    cap = (rd || wr) && ok && (m_trig || hit) && !m_ovf;
    if (hit) begin m_trig = 1; m_armed = 0; end
    if (cap) begin
      if (mq.size() == DEPTH) m_ovf = 1;
      else mq.push_back({wr, a, d});
    end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; filt_ok = 1'b0;
  endtask

  task automatic cfg_read(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a; cfg_re = 1'b1;
    #1 v = cfg_rdata;
    if (a == 3'd5 && mq.size() > 0) void'(mq.pop_front());
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  task automatic chk_stat(string req);
    logic [31:0] v;
    cfg_read(3'd3, v);
    chk(req, v, exp_stat());
  endtask

  // read head record then pop it, checking both words
  task automatic chk_pop(string req);
    logic [31:0] v;
    logic [32:0] h;
    if (mq.size() == 0) return;
    h = mq[0];
    cfg_read(3'd4, v);
    chk(req, v, {h[32], 15'd0, h[31:16]});
    cfg_read(3'd5, v);
    chk(req, v, {16'd0, h[15:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 R9: reset state
    chk_stat("R9 reset status");
    cfg_read(3'd0, v); chk("R9 ctrl reset", v, 32'd0);

    // R8: not armed, no trigger
    cfg_write(3'd1, 32'h20);
    cfg_write(3'd0, 32'hC);
    txn(1, 0, 16'h20, 16'h0, 16'h1111, 1);
    chk_stat("R8 unarmed no trigger");
    cfg_read(3'd0, v); chk("R9 ctrl readback", v, 32'hC);

    // R2 R5 R1 R6: arm, trigger on read, then a write
    cfg_write(3'd0, 32'hD);
    chk_stat("R8 armed");
    txn(0, 1, 16'h10, 16'h7777, 16'h0, 1);
    chk_stat("R2 no capture before trigger");
    txn(1, 0, 16'h20, 16'h9999, 16'h1234, 1);
    txn(0, 1, 16'h30, 16'h0055, 16'hFFFF, 1);
    chk_stat("R5 trigger record stored");
    chk_pop("R1 R6 first record is trigger read");
    chk_pop("R1 R6 second record write");
    chk_stat("R6 empty after pops");
    cfg_read(3'd5, v);
    chk_stat("R6 pop when empty ignored");

    // R3 R4: write-only with data match
    cfg_write(3'd2, 32'hAB);
    cfg_write(3'd0, 32'hB);
    txn(0, 1, 16'h20, 16'h0000, 16'h0, 1);
    chk_stat("R3 data mismatch no trigger");
    txn(1, 0, 16'h20, 16'h0, 16'h00AB, 1);
    chk_stat("R4 read blocked by write-only mode");
    txn(0, 1, 16'h20, 16'h00AB, 16'h0, 0);
    chk_stat("R5 rejected trigger still fires, not stored");
    txn(1, 1, 16'h40, 16'h0BEE, 16'h0CAF, 1);
    chk_pop("R1 both strobes stored as write");

    // R4: mode none never triggers
    cfg_write(3'd0, 32'h1);
    txn(1, 0, 16'h20, 16'h0, 16'h00AB, 1);
    txn(0, 1, 16'h20, 16'h00AB, 16'h0, 1);
    chk_stat("R4 mode none never triggers");

    // R7 R8: overflow
    cfg_write(3'd0, 32'hD);
    for (int i = 0; i < DEPTH + 2; i++) txn(0, 1, 16'h20 + 16'(i), 16'(i), 16'h0, 1);
    chk_stat("R7 full and overflow");
    chk_pop("R7 oldest record kept");
    txn(0, 1, 16'h99, 16'h1, 16'h0, 1);
    chk_stat("R7 no capture after overflow even with room");
    cfg_write(3'd0, 32'hD);
    chk_stat("R8 arm clears fifo and flags");

    // random phase
    for (int it = 0; it < 1500; it++) begin
      int unsigned op = $urandom_range(0, 99);
      logic [15:0] a = 16'h20 + 16'($urandom_range(0, 3) * 16);
      logic [15:0] d = 16'($urandom_range(0, 2) == 0 ? 16'hAB : $urandom_range(0, 3));
      if (op < 45) begin
        txn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d,
            16'($urandom_range(0, 1) ? 16'hAB : 16'h3), 1'($urandom_range(0, 3) != 0));
      end else if (op < 60) begin
        chk_stat("R9 random status");
      end else if (op < 80) begin
        if (mq.size() > 0) chk_pop("R6 random record order");
        else chk_stat("R6 random empty");
      end else if (op < 85) begin
        cfg_write(3'd0, {28'd0, 2'($urandom_range(1, 3)), 1'($urandom_range(0, 1)), 1'b1});
      end else if (op < 88) begin
        cfg_write(3'd1, 32'(a));
      end else if (op < 90) begin
        cfg_write(3'd2, 32'(d));
      end else begin
        chk_stat("R7 random status");
      end
    end
    while (mq.size() > 0) chk_pop("R6 drain");
    chk_stat("R9 final status");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule